// File: doc/BRIEF.md
# Low-Order Interleaved Word Store

This block fronts a set of M equal storage banks, each of which needs M clock cycles to finish one access, and makes them behave as a single word-addressed store that can take a new request on every cycle. The bank is chosen by the low address bits, so a run of consecutive word addresses visits every bank in turn. Each bank keeps an address register, a data register and a countdown for its own access, so up to M accesses are in progress at once, each at a different stage.

A requester presents an address, a write flag and write data with a valid/ready handshake. Ready goes low only when the bank that the presented address selects is still working on an earlier access. Reads come back on a response stream with no backpressure. The response appears a fixed M cycles after the request was taken, so responses leave in the same order the requests were accepted. Writes take the same M cycles inside their bank and produce no response.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank index is `req_addr[log2(M)-1:0]` and the word within the bank is the remaining upper address bits. Every one of the 2^ADDR_W addresses holds its own word.
- R2: While reset is held and in the first cycle after it, `req_ready` is 1 and `rsp_valid` is 0.
- R3: Once a bank accepts a request, `req_ready` is 0 during the next M-1 cycles whenever `req_addr` selects that bank.
- R4: A bank that accepted a request at clock edge e can accept again at edge e+M, so a stride of M words is taken once every M cycles.
- R5: A stream of consecutive addresses is accepted at one request per cycle with no stall.
- R6: Each accepted read raises `rsp_valid` for exactly one cycle, visible just after the M-th rising edge following the accepting edge. No other cycle has `rsp_valid` high.
- R7: An accepted write produces no response.
- R8: Responses carry the data of the read addresses in the order the reads were accepted.
- R9: A read accepted after a write to the same address returns the written data, even when it is issued right behind the write.
- R10: While `req_valid` is 0, no request is taken and no bank becomes busy, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | The selected bank can take the request this cycle |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The checker assumes that `req_addr` and `req_write` are known whenever `req_valid` is high, and that the requester holds a refused request until it is taken. The bench holds inputs steady from one falling edge to the next and reissues every refused request. It never lowers valid on a pending request. The response stream has no ready signal, so the checks do not depend on a consumer keeping up. The bench drives consecutive, same-bank-stride, write-then-read and random mixed traffic with idle gaps. A behavioural model tracks when each bank becomes free and which responses are due.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

endpackage

// File: rtl/ilv_addr_dec.sv
module ilv_addr_dec #(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [BANK_W-1:0]    bank_o,
    output logic [ROW_W-1:0]     row_o,
    output logic [NUM_BANKS-1:0] sel_o
);

    // low bits pick the bank, upper bits pick the word inside it
    assign bank_o = addr_i[BANK_W-1:0];
    assign row_o  = addr_i[ADDR_W-1:BANK_W];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        assign sel_o[g] = (bank_o == BANK_W'(g));
    end

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 6,
    parameter int DATA_W    = 16,
    localparam int CNT_W    = $clog2(NUM_BANKS + 1),
    localparam int ROWS     = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  op_e               op_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              free_o,
    output logic              rd_vld_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;      // cycles left, including the finishing one
        logic [ROW_W-1:0]  mar;      // latched word address
        logic [DATA_W-1:0] mdr;      // latched write data
        op_e               op;
        logic              rd_vld;
        logic [DATA_W-1:0] rd_data;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [DATA_W-1:0] store [ROWS];
    logic              finish;
    logic              mem_we;

    always_comb begin
        st_d   = st_q;
        finish = (st_q.cnt == CNT_W'(1));
        mem_we = finish && (st_q.op == OP_WR);

        st_d.rd_vld = finish && (st_q.op == OP_RD);
        if (finish && (st_q.op == OP_RD)) begin
            st_d.rd_data = store[st_q.mar];
        end

        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        // a new access may be loaded in the last cycle of the previous one
        if (start_i) begin
            st_d.cnt = CNT_W'(NUM_BANKS);
            st_d.mar = row_i;
            st_d.mdr = wdata_i;
            st_d.op  = op_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            store[st_q.mar] <= st_q.mdr;
        end
    end

    assign free_o    = (st_q.cnt <= CNT_W'(1));
    assign rd_vld_o  = st_q.rd_vld;
    assign rd_data_o = st_q.rd_data;

endmodule

// File: rtl/ilv_rsp_mux.sv
module ilv_rsp_mux #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 16
) (
    input  logic [NUM_BANKS-1:0]             vld_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] data_i,
    output logic                             vld_o,
    output logic [DATA_W-1:0]                data_o
);

    // at most one bank finishes per cycle, so an AND-OR merge suffices
    always_comb begin
        vld_o  = 1'b0;
        data_o = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            vld_o = vld_o | vld_i[i];
            if (vld_i[i]) begin
                data_o = data_o | data_i[i];
            end
        end
    end

endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic [BANK_W-1:0]               bank_idx;
    logic [ROW_W-1:0]                row;
    logic [NUM_BANKS-1:0]            bank_sel;
    logic [NUM_BANKS-1:0]            bank_free;
    logic [NUM_BANKS-1:0]            bank_start;
    logic [NUM_BANKS-1:0]            rd_vld;
    logic [NUM_BANKS-1:0][DATA_W-1:0] rd_data;
    logic                            take;
    op_e                             op;

    ilv_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS)
    ) u_dec (
        .addr_i(req_addr),
        .bank_o(bank_idx),
        .row_o (row),
        .sel_o (bank_sel)
    );

    always_comb begin
        req_ready  = bank_free[bank_idx];
        take       = req_valid && req_ready;
        bank_start = bank_sel & {NUM_BANKS{take}};
        op         = req_write ? OP_WR : OP_RD;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ilv_bank #(
            .NUM_BANKS(NUM_BANKS),
            .ROW_W    (ROW_W),
            .DATA_W   (DATA_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (bank_start[g]),
            .op_i     (op),
            .row_i    (row),
            .wdata_i  (req_wdata),
            .free_o   (bank_free[g]),
            .rd_vld_o (rd_vld[g]),
            .rd_data_o(rd_data[g])
        );
    end

    ilv_rsp_mux #(
        .NUM_BANKS(NUM_BANKS),
        .DATA_W   (DATA_W)
    ) u_mux (
        .vld_i (rd_vld),
        .data_i(rd_data),
        .vld_o (rsp_valid),
        .data_o(rsp_rdata)
    );

endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [BANK_W-1:0]    req_bank,
    input logic                 rsp_valid,
    input logic [NUM_BANKS-1:0] bank_start
);

    logic                 acc;
    logic [NUM_BANKS-1:0] rd_pipe;
    logic [NUM_BANKS-1:0] wr_pipe;
    logic [BANK_W-1:0]    hold [NUM_BANKS];

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pipe <= '0;
            wr_pipe <= '0;
            for (int i = 0; i < NUM_BANKS; i++) hold[i] <= '0;
        end else begin
            rd_pipe <= {rd_pipe[NUM_BANKS-2:0], acc && !req_write};
            wr_pipe <= {wr_pipe[NUM_BANKS-2:0], acc && req_write};
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (acc && (req_bank == BANK_W'(i))) hold[i] <= BANK_W'(NUM_BANKS - 1);
                else if (hold[i] != '0)              hold[i] <= hold[i] - BANK_W'(1);
            end
        end
    end

    p_bank_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (hold[req_bank] == '0));

    p_single_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_start));

    p_free_bank_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[req_bank] == '0) |-> req_ready);

    p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pipe[NUM_BANKS-1] |=> rsp_valid);

    p_no_stray_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pipe[NUM_BANKS-1] |=> !rsp_valid);

    p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pipe[NUM_BANKS-1] |=> !rsp_valid);

    p_idle_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (bank_start == '0));

endmodule

bind ilv_mem_ctrl ilv_mem_chk #(
    .NUM_BANKS(NUM_BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_bank  (bank_idx),
    .rsp_valid (rsp_valid),
    .bank_start(bank_start)
);

// File: tb/tb_ilv_mem_ctrl.sv
module tb_ilv_mem_ctrl;

    localparam int NB    = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    always #2 clk = ~clk;

    ilv_mem_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    // reference model state
    int            cyc = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    logic [DW-1:0] mem_m [DEPTH];
    int            bank_next [NB];
    int            due_q [$];
    logic [DW-1:0] dat_q [$];
    string         rdy_tag  = "R2";
    string         rsp_tag  = "R6";
    string         data_tag = "R8";
    int            acc_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic check_rsp();
        bit exp_v;
        exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
        chk(rsp_valid == exp_v, rsp_tag, rsp_valid, exp_v);
        if (exp_v) begin
            chk(rsp_rdata == dat_q[0], data_tag, rsp_rdata, dat_q[0]);
            void'(due_q.pop_front());
            void'(dat_q.pop_front());
        end
    endtask

    task automatic step(input bit v, input logic [AW-1:0] a, input bit w,
                        input logic [DW-1:0] d, output bit acc);
        int b;
        bit exp_rdy;
        @(negedge clk);
        check_rsp();
        req_valid = v;
        req_addr  = a;
        req_write = w;
        req_wdata = d;
        #1;
        b       = int'(a) % NB;
        exp_rdy = (cyc + 1 >= bank_next[b]);
        chk(req_ready == exp_rdy, rdy_tag, req_ready, exp_rdy);
        acc = v && req_ready;
        if (acc) begin
            acc_cyc      = cyc;
            bank_next[b] = cyc + 1 + NB;
            if (w) mem_m[a] = d;
            else begin
                due_q.push_back(cyc + 1 + NB);
                dat_q.push_back(mem_m[a]);
            end
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d);
        bit acc;
        do step(1'b1, a, w, d, acc); while (!acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, AW'($urandom), 1'($urandom), DW'($urandom), acc);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 16'h0101) ^ 16'h5a5a;
    endfunction

    initial begin
        int first;
        int prev;
        for (int i = 0; i < NB; i++) bank_next[i] = 0;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R2", req_ready, 1);
        chk(rsp_valid == 1'b0, "R2", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", req_ready, 1);
        chk(rsp_valid == 1'b0, "R2", rsp_valid, 0);

        // R5, R7: consecutive writes fill every address, one per cycle
        rdy_tag = "R5"; rsp_tag = "R7";
        for (int a = 0; a < DEPTH; a++) begin
            issue(AW'(a), 1'b1, pat(a));
            if (a == 0) first = acc_cyc;
        end
        chk(acc_cyc - first == DEPTH - 1, "R5", acc_cyc - first, DEPTH - 1);
        rdy_tag = "R10";
        idle(NB + 2);

        // R5, R6, R8: consecutive reads
        rdy_tag = "R5"; rsp_tag = "R6"; data_tag = "R8";
        for (int a = 0; a < DEPTH; a++) begin
            issue(AW'(a), 1'b0, '0);
            if (a == 0) first = acc_cyc;
        end
        chk(acc_cyc - first == DEPTH - 1, "R5", acc_cyc - first, DEPTH - 1);
        rdy_tag = "R10";
        idle(NB + 2);

        // R1, R3, R4: stride of NB stays in one bank, different rows
        rdy_tag = "R4"; data_tag = "R1";
        for (int k = 0; k < 16; k++) begin
            issue(AW'(k * NB + 1), 1'b0, '0);
            if (k > 0) chk(acc_cyc - prev == NB, "R4", acc_cyc - prev, NB);
            prev = acc_cyc;
        end
        rdy_tag = "R3";
        for (int k = 0; k < NB; k++) issue(AW'(8 * NB + k), 1'b0, '0);
        rdy_tag = "R10";
        idle(NB + 2);

        // R9: write then immediate read of the same address
        rdy_tag = "R3"; data_tag = "R9";
        for (int k = 0; k < 12; k++) begin
            issue(AW'(k * 37 + 3), 1'b1, DW'(16'hc300 + k));
            issue(AW'(k * 37 + 3), 1'b0, '0);
            issue(AW'(k * 37 + 4), 1'b1, DW'(16'h3c00 + k));
            issue(AW'(k * 37 + 4), 1'b0, '0);
        end
        rdy_tag = "R10";
        idle(NB + 2);

        // R3, R8: random mix with idle gaps
        rdy_tag = "R3"; data_tag = "R8"; rsp_tag = "R6";
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
            issue(AW'($urandom), 1'($urandom), DW'($urandom));
        end

        // R10: idle inputs with garbage must not occupy any bank
        rdy_tag = "R10";
        idle(NB + 4);
        for (int a = 0; a < NB; a++) begin
            @(negedge clk);
            check_rsp();
            req_valid = 1'b0;
            req_addr  = AW'(a);
            #1;
            chk(req_ready == 1'b1, "R10", req_ready, 1);
        end
        chk(due_q.size() == 0, "R6", due_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule